// File: doc/BRIEF.md
# Three-Port Bridge Target Claim Logic

This block decides, for one bus interface of a bridge that links a primary bus with two secondary buses, whether a new bus cycle is taken by the bridge. It acts on the clock edge where FRAME# is first seen low. At that edge it captures the command and the address, notes which port the initiator sits on, and reads a port-hit vector from the address decoder. A cycle is claimed only when the address maps to a port other than the initiator's own port.

A claimed cycle gets DEVSEL# after a delay set by a two-bit speed setting. A memory write or a memory write-and-invalidate is posted: TRDY# comes with DEVSEL# and the cycle ends normally. Every other command is a delayed transaction. The first such cycle is retried and stored in a single pending record (command and address), and a forward request goes to the far port. Repeats of that cycle are retried until the far port reports completion. The next repeat with the same command and address then ends normally and clears the record. A cycle that does not match is retried while a record is pending, and it is not stored.

Top module: `bridge_claim`

## Requirements
- R1: While reset is held and after it is released with no cycle on the bus, devsel_n, trdy_n and stop_n are high and drv_en and fwd_valid are low.
- R2: Port codes are 0 primary, 1 secondary A, 2 secondary B. Bit i of hit means the address maps to port i. When the decoded port equals init_port, the cycle is not claimed: devsel_n stays high and fwd_valid stays low.
- R3: When hit is all zero, the cycle is not claimed, so the initiator sees a master abort.
- R4: When the initiator is on port 0 and other_devsel_n is sampled low during the decode wait, before the block's own slot, the cycle is not claimed.
- R5: Counting the edge where FRAME# is first sampled low as edge 0, devsel_n goes low just after edge 1, 2 or 3 for speed 0 (fast), 1 (medium) or 2 (slow). Speed 3 behaves like speed 2.
- R6: A claimed cycle with cmd 4'b0111 or 4'b1111 is posted. trdy_n goes low together with devsel_n, stop_n stays high, and fwd_valid pulses for one clock in the same cycle. fwd_port then shows the target port and fwd_cmd and fwd_addr show the captured command and address.
- R7: A claimed cycle with any other command, when no record is pending, is retried. stop_n goes low with devsel_n, trdy_n stays high and never overlaps stop_n, and fwd_valid pulses once as the record is stored.
- R8: A repeat with the same command and address, made before far_done has been seen, is retried again and fwd_valid stays low.
- R9: A delayed cycle whose command or address differs from the pending record is retried without fwd_valid, and the record is left unchanged.
- R10: After a far_done pulse, the next matching repeat ends normally (trdy_n low, stop_n high, no fwd_valid) and clears the record, so a later identical cycle is stored again as a new one.
- R11: A transfer ends at the edge where FRAME# is high and IRDY# and TRDY# are low. During the next clock devsel_n and trdy_n are high while drv_en stays high, and drv_en drops one clock later.
- R12: A retried cycle ends at the first edge where FRAME# is sampled high, and then releases in the same way as in R11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| other_devsel_n | input | 1 | DEVSEL# driven by other targets on the bus |
| far_done | input | 1 | Pulse: the far port has completed the pending delayed transaction |
| init_port | input | 2 | Port of the current initiator (0, 1, 2) |
| hit | input | 3 | One-hot port hit from address decode |
| cmd | input | 4 | Bus command in the address phase |
| addr | input | ADDR_W | Address in the address phase |
| speed | input | 2 | DEVSEL# timing setting |
| devsel_n | output | 1 | DEVSEL# drive value |
| trdy_n | output | 1 | TRDY# drive value |
| stop_n | output | 1 | STOP# drive value |
| drv_en | output | 1 | Output enable for the target control lines |
| fwd_valid | output | 1 | One-clock request to forward the cycle |
| fwd_port | output | 2 | Destination port of the forwarded cycle |
| fwd_cmd | output | 4 | Forwarded command |
| fwd_addr | output | ADDR_W | Forwarded address |

## Verification
The pending record and its done flag cannot be seen directly. A corrupt record shows up on a later repeat as a wrong termination type: a retry where normal completion is due, a normal completion where a retry is due, or a missing or extra fwd_valid. It is visible within three clocks of the repeat's address phase. A wrong decode counter moves the first DEVSEL# clock, and a broken release state shows in drv_en one or two clocks after the final transfer. Because of this, each delayed scenario is followed by a repeat that reads the record back through the termination it causes.

// File: rtl/bridge_claim.sv
module bridge_claim #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              other_devsel_n,
  input  logic              far_done,
  input  logic [1:0]        init_port,
  input  logic [2:0]        hit,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        speed,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              drv_en,
  output logic              fwd_valid,
  output logic [1:0]        fwd_port,
  output logic [3:0]        fwd_cmd,
  output logic [ADDR_W-1:0] fwd_addr
);

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_XFER, S_RETRY, S_TURN, S_IGN} st_t;

  st_t              st;
  logic             frame_q;
  logic [1:0]       cnt;
  logic             cyc_pri;
  logic [1:0]       cyc_tgt;
  logic [3:0]       cyc_cmd;
  logic [ADDR_W-1:0] cyc_addr;
  logic             pend_valid;
  logic             pend_done;
  logic [3:0]       pend_cmd;
  logic [ADDR_W-1:0] pend_addr;

  logic [1:0] tgt_in;
  logic       tgt_ok;
  logic       start;
  logic [1:0] spd_lim;
  logic       postable;
  logic       match;

  assign tgt_in   = hit[0] ? 2'd0 : (hit[1] ? 2'd1 : 2'd2);
  assign tgt_ok   = (|hit) && (init_port != 2'd3) && (tgt_in != init_port);
  assign start    = (st == S_IDLE) && frame_q && !frame_n;
  assign spd_lim  = (speed == 2'd3) ? 2'd2 : speed;
  assign postable = (cyc_cmd[2:0] == 3'b111);
  assign match    = pend_valid && (pend_cmd == cyc_cmd) && (pend_addr == cyc_addr);

  assign devsel_n = !((st == S_XFER) || (st == S_RETRY));
  assign trdy_n   = !(st == S_XFER);
  assign stop_n   = !(st == S_RETRY);
  assign drv_en   = (st == S_XFER) || (st == S_RETRY) || (st == S_TURN);
  assign fwd_port = cyc_tgt;
  assign fwd_cmd  = cyc_cmd;
  assign fwd_addr = cyc_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      frame_q    <= 1'b1;
      cnt        <= '0;
      cyc_pri    <= 1'b0;
      cyc_tgt    <= '0;
      cyc_cmd    <= '0;
      cyc_addr   <= '0;
      pend_valid <= 1'b0;
      pend_done  <= 1'b0;
      pend_cmd   <= '0;
      pend_addr  <= '0;
      fwd_valid  <= 1'b0;
    end else begin
      frame_q   <= frame_n;
      fwd_valid <= 1'b0;
      if (far_done && pend_valid) pend_done <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          cyc_pri  <= (init_port == 2'd0);
          cyc_tgt  <= tgt_in;
          cyc_cmd  <= cmd;
          cyc_addr <= addr;
          cnt      <= '0;
          st       <= tgt_ok ? S_DEC : S_IGN;
        end
        S_DEC: begin
          if (cyc_pri && !other_devsel_n) begin
            st <= S_IGN;
          end else if (cnt == spd_lim) begin
            if (postable) begin
              fwd_valid <= 1'b1;
              st        <= S_XFER;
            end else if (!pend_valid) begin
              pend_valid <= 1'b1;
              pend_done  <= 1'b0;
              pend_cmd   <= cyc_cmd;
              pend_addr  <= cyc_addr;
              fwd_valid  <= 1'b1;
              st         <= S_RETRY;
            end else if (match && pend_done) begin
              pend_valid <= 1'b0;
              pend_done  <= 1'b0;
              st         <= S_XFER;
            end else begin
              st <= S_RETRY;
            end
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
        S_XFER:  if (frame_n && !irdy_n) st <= S_TURN;
        S_RETRY: if (frame_n) st <= S_TURN;
        S_TURN:  st <= S_IDLE;
        S_IGN:   if (frame_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bridge_claim_chk.sv
module bridge_claim_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic irdy_n,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic drv_en,
  input logic fwd_valid
);

  AST_TRDY_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!trdy_n && !stop_n)); // R7
  AST_TRDY_WITH_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n) !trdy_n |-> !devsel_n); // R6
  AST_STOP_WITH_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n) !stop_n |-> !devsel_n); // R7
  AST_DRIVE_WHILE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n) !devsel_n |-> drv_en); // R11
  AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(devsel_n) |-> (drv_en && trdy_n && stop_n)); // R11
  AST_RELEASE_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(devsel_n) |=> !drv_en); // R11
  AST_FWD_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) fwd_valid |=> !fwd_valid); // R6
  AST_XFER_END: assert property (@(posedge clk) disable iff (!rst_n) (!trdy_n && !irdy_n && frame_n) |=> devsel_n); // R11
  AST_RETRY_END: assert property (@(posedge clk) disable iff (!rst_n) (!stop_n && frame_n) |=> devsel_n); // R12

endmodule

bind bridge_claim bridge_claim_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
  .drv_en(drv_en), .fwd_valid(fwd_valid)
);

// File: tb/bridge_claim_test.sv
module bridge_claim_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, other_devsel_n = 1'b1, far_done = 1'b0;
  logic [1:0] init_port = '0;
  logic [2:0] hit = '0;
  logic [3:0] cmd = '0;
  logic [31:0] addr = '0;
  logic [1:0] speed = '0;
  logic devsel_n, trdy_n, stop_n, drv_en, fwd_valid;
  logic [1:0] fwd_port;
  logic [3:0] fwd_cmd;
  logic [31:0] fwd_addr;

  int n_chk = 0, n_fail = 0;
  int g_k, g_rel, g_hold, g_end, g_trdy, g_stop, g_fwd, g_fport, g_fcmd;
  logic [31:0] g_faddr;

  always #2.5 clk = ~clk;

  bridge_claim #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .other_devsel_n(other_devsel_n), .far_done(far_done), .init_port(init_port),
    .hit(hit), .cmd(cmd), .addr(addr), .speed(speed),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .drv_en(drv_en),
    .fwd_valid(fwd_valid), .fwd_port(fwd_port), .fwd_cmd(fwd_cmd), .fwd_addr(fwd_addr)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run(input logic [1:0] ip, input logic [2:0] h, input logic [3:0] c,
                     input logic [31:0] a, input logic [1:0] sp, input logic oth);
    step();
    speed = sp; init_port = ip; hit = h; cmd = c; addr = a;
    frame_n = 1'b0; irdy_n = 1'b1;
    step();
    frame_n = 1'b1; irdy_n = 1'b0; other_devsel_n = !oth;
    g_k = 0; g_rel = 0; g_hold = -1; g_end = -1; g_trdy = 1; g_stop = 1; g_fwd = 0;
    for (int k = 1; k <= 6; k++) begin
      step();
      if (fwd_valid) begin
        g_fwd++; g_fport = fwd_port; g_fcmd = fwd_cmd; g_faddr = fwd_addr;
      end
      if (g_rel != 0 && k == g_rel + 1) g_end = drv_en;
      if (!devsel_n && g_k == 0) begin g_k = k; g_trdy = trdy_n; g_stop = stop_n; end
      if (devsel_n && g_k != 0 && g_rel == 0) begin g_rel = k; g_hold = drv_en; end
    end
    irdy_n = 1'b1; other_devsel_n = 1'b1;
  endtask

  task automatic expect_none(input string req);
    check({req, " devsel never"}, g_k, 0);
    check({req, " no forward"}, g_fwd, 0);
  endtask

  task automatic t_reset();
    check("R1 devsel_n", devsel_n, 1);
    check("R1 trdy_n", trdy_n, 1);
    check("R1 stop_n", stop_n, 1);
    check("R1 drv_en", drv_en, 0);
    check("R1 fwd_valid", fwd_valid, 0);
  endtask

  task automatic t_no_claim();
    run(2'd0, 3'b001, 4'b0111, 32'h100, 2'd0, 1'b0); expect_none("R2 pri->pri");
    run(2'd1, 3'b010, 4'b0111, 32'h104, 2'd0, 1'b0); expect_none("R2 secA->secA");
    run(2'd2, 3'b100, 4'b0110, 32'h108, 2'd1, 1'b0); expect_none("R2 secB->secB");
    run(2'd0, 3'b000, 4'b0111, 32'h10C, 2'd0, 1'b0); expect_none("R3 pri no hit");
    run(2'd1, 3'b000, 4'b0110, 32'h110, 2'd0, 1'b0); expect_none("R3 sec no hit");
    run(2'd0, 3'b010, 4'b0111, 32'h114, 2'd2, 1'b1); expect_none("R4 other devsel");
  endtask

  task automatic t_speed();
    for (int s = 0; s < 4; s++) begin
      run(2'd0, 3'b010, 4'b0111, 32'h200 + s, s[1:0], 1'b0);
      check($sformatf("R5 speed %0d edge", s), g_k, (s == 3) ? 3 : s + 1);
      check("R11 release clock", g_rel, g_k + 1);
      check("R11 drive held", g_hold, 1);
      check("R11 drive dropped", g_end, 0);
    end
  endtask

  task automatic t_posted();
    run(2'd1, 3'b001, 4'b1111, 32'hA0A0, 2'd0, 1'b0);
    check("R6 trdy low", g_trdy, 0);
    check("R6 stop high", g_stop, 1);
    check("R6 one forward", g_fwd, 1);
    check("R6 fwd port", g_fport, 0);
    check("R6 fwd cmd", g_fcmd, 4'b1111);
    check("R6 fwd addr", g_faddr, 32'hA0A0);
    run(2'd2, 3'b010, 4'b0111, 32'hB0B0, 2'd1, 1'b0);
    check("R6 secB->secA port", g_fport, 1);
    check("R6 secB->secA trdy", g_trdy, 0);
  endtask

  task automatic t_delayed();
    run(2'd0, 3'b100, 4'b0110, 32'h5000, 2'd0, 1'b0);
    check("R7 retry stop", g_stop, 0);
    check("R7 retry trdy", g_trdy, 1);
    check("R7 forward", g_fwd, 1);
    check("R7 fwd port", g_fport, 2);
    check("R7 fwd cmd", g_fcmd, 4'b0110);
    check("R12 release clock", g_rel, g_k + 1);
    check("R12 drive dropped", g_end, 0);
    run(2'd0, 3'b100, 4'b0110, 32'h5000, 2'd0, 1'b0);
    check("R8 repeat retry", g_stop, 0);
    check("R8 no forward", g_fwd, 0);
    run(2'd0, 3'b100, 4'b0110, 32'h6000, 2'd0, 1'b0);
    check("R9 mismatch retry", g_stop, 0);
    check("R9 no forward", g_fwd, 0);
    run(2'd0, 3'b100, 4'b0010, 32'h5000, 2'd0, 1'b0);
    check("R9 cmd mismatch retry", g_stop, 0);
    check("R9 cmd mismatch no forward", g_fwd, 0);
    step(); far_done = 1'b1; step(); far_done = 1'b0;
    run(2'd0, 3'b100, 4'b0010, 32'h5000, 2'd0, 1'b0);
    check("R9 mismatch after done retry", g_stop, 0);
    run(2'd0, 3'b100, 4'b0110, 32'h5000, 2'd0, 1'b0);
    check("R10 complete trdy", g_trdy, 0);
    check("R10 complete stop", g_stop, 1);
    check("R10 complete no forward", g_fwd, 0);
    check("R11 complete release", g_end, 0);
    run(2'd0, 3'b100, 4'b0110, 32'h5000, 2'd0, 1'b0);
    check("R10 cleared new retry", g_stop, 0);
    check("R10 cleared new forward", g_fwd, 1);
    step(); far_done = 1'b1; step(); far_done = 1'b0;
    run(2'd0, 3'b100, 4'b0110, 32'h5000, 2'd0, 1'b0);
    check("R10 second completion", g_trdy, 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_no_claim();
    t_speed();
    t_posted();
    t_delayed();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule